// File: doc/BRIEF.md
# PHY management serial master

This block is a register-driven master for the two-wire serial management bus used to reach the control and status registers of an Ethernet PHY. A host writes a small set of word registers to program the management clock rate, pick the PHY and register to address, and supply write data. It then issues a single read, a single write or a continuous background scan of one register, and watches the busy flag until the transfer has finished.

On the PHY side the block drives the management clock, the serial data output and its output enable, and samples the serial data input. A frame is an optional run of ones, a start pattern, an opcode, the two addresses, a turnaround and sixteen data bits. The frame is shifted out MSB first. Output data changes after a falling clock edge, and input data is captured on a rising edge.

In scan mode the block reads the selected register again and again with no idle gap. From each result it refreshes the read-data register and a link-failure flag. A flag marking the scan data as not yet valid stays set until the first scan read completes.

Top module: `mdio_master`

## Requirements
- R1: While a frame runs, the management clock period is 2*max(1, mode[7:1]) system clock cycles, so mode bit 0 is ignored and values 0 and 1 both give a period of 2. When no frame runs, the clock is held low and the output enable is low.
- R2: A frame is 32 ones, start bits 0 then 1, opcode (10 read, 01 write), PHY address (address register bits [4:0]), register address (address register bits [12:8]), two turnaround bits and 16 data bits, all MSB first. Output data is stable at each rising clock edge.
- R3: When mode bit 8 is 1, the 32 leading ones are left out and the frame begins with the start bits.
- R4: In a write frame the turnaround is driven as 1 then 0, followed by bits [15:0] of the write-data register, with the output enable high for the whole frame.
- R5: In a read frame the output enable is low during turnaround and data. The input is sampled on the rising clock edges of the 16 data bits, and the read-data register takes the new value only when the frame ends.
- R6: Status bit 1 (busy) reads 1 in the cycle after a command is accepted. It goes back to 0 only after the last data bit of the last frame.
- R7: Command register bit 0 starts a scan, bit 1 a single read and bit 2 a single write. When several bits are set, write beats read and read beats scan. A command register write while busy starts no frame.
- R8: A scan repeats read frames of the addressed register for as long as command bit 0 stays set. After the bit is cleared, the frame in progress completes and no further frame starts.
- R9: Status bit 2 is set when a scan starts and cleared when its first read completes. Status bit 0 (link failure) takes bit 2 of each scan read result.
- R10: Host register index: 0 mode, 1 command, 2 address, 3 write data, 4 read data (zero-extended), 5 status. Reads have no side effects, and after reset status and read data are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 3 | Host register index |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Serial data output enable |
| mdio_i | input | 1 | Serial data in |

## Verification
The bench builds the block with its default parameters: a 5-bit PHY and register address, 16 data bits and a 32-bit preamble, which give 64-bit frames. It reaches different clock rates by programming the mode register at run time, with divider values 0, 7, 9 and 4. These make the minimum period of two system cycles and the odd-value rounding observable, with and without the preamble. The short periods keep each frame to a few hundred cycles, so that back-to-back scan frames, a command written mid-frame and the command priority orderings all fit in one run.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_AW  = 5;
  localparam int REG_AW  = 5;
  localparam int DATA_W  = 16;
  localparam int PRE_LEN = 32;
  localparam int DIV_W   = 8;
  localparam int REG_LSB = 8;
  localparam int LINK_BIT = 2;
  localparam int BODY_W  = 4 + PHY_AW + REG_AW + 2 + DATA_W;
  localparam int FRAME_W = PRE_LEN + BODY_W;
  localparam int POS_W   = $clog2(FRAME_W);

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_WR   = 2'b01,
    OP_RD   = 2'b10
  } mdio_op_e;

  typedef enum logic [2:0] {
    SEL_MODE  = 3'd0,
    SEL_CMD   = 3'd1,
    SEL_ADDR  = 3'd2,
    SEL_WDATA = 3'd3,
    SEL_RDATA = 3'd4,
    SEL_STAT  = 3'd5
  } host_sel_e;

  // half MDC period in system cycles; an odd value is rounded down, minimum 1
  function automatic logic [DIV_W-2:0] half_period(input logic [DIV_W-1:0] div);
    if (div[DIV_W-1:1] == '0) return (DIV_W-1)'(1);
    return div[DIV_W-1:1];
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(input mdio_op_e op,
                                                     input logic [PHY_AW-1:0] phy,
                                                     input logic [REG_AW-1:0] regad,
                                                     input logic [DATA_W-1:0] data);
    logic [1:0]        ta;
    logic [DATA_W-1:0] pay;
    ta  = (op == OP_WR) ? 2'b10 : 2'b00;
    pay = (op == OP_WR) ? data : '0;
    return {{PRE_LEN{1'b1}}, 2'b01, op, phy, regad, ta, pay};
  endfunction

  function automatic logic [POS_W-1:0] first_pos(input logic nopre);
    return nopre ? POS_W'(BODY_W - 1) : POS_W'(FRAME_W - 1);
  endfunction

  // command decode: write beats read, read beats scan
  function automatic mdio_op_e pick_op(input logic [2:0] cmd);
    if (cmd[2]) return OP_WR;
    if (cmd[1] || cmd[0]) return OP_RD;
    return OP_NONE;
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-2:0] half,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-2:0] cnt;
  logic             wrap;

  assign wrap     = run && (cnt >= half - 1'b1);
  assign rise_evt = wrap && !mdc;
  assign fall_evt = wrap && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_pkg::*;
#(
  parameter logic [DIV_W-1:0] DIV_RESET = 8'd100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        sel,
  input  logic              we,
  input  logic [31:0]       wdata,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [2:0]        status,
  output logic [DIV_W-1:0]  mode_div,
  output logic              nopre,
  output logic [2:0]        cmd_q,
  output logic              cmd_wr,
  output logic [2:0]        cmd_wval,
  output logic [PHY_AW-1:0] phy,
  output logic [REG_AW-1:0] regad,
  output logic [DATA_W-1:0] wr_data,
  output logic [31:0]       rdata
);
  assign cmd_wr   = we && (sel == SEL_CMD);
  assign cmd_wval = wdata[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_div <= DIV_RESET;
      nopre    <= 1'b0;
      cmd_q    <= '0;
      phy      <= '0;
      regad    <= '0;
      wr_data  <= '0;
    end else if (we) begin
      case (sel)
        SEL_MODE: begin
          mode_div <= wdata[DIV_W-1:0];
          nopre    <= wdata[DIV_W];
        end
        SEL_CMD:   cmd_q <= wdata[2:0];
        SEL_ADDR: begin
          phy   <= wdata[PHY_AW-1:0];
          regad <= wdata[REG_LSB +: REG_AW];
        end
        SEL_WDATA: wr_data <= wdata[DATA_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_MODE:  rdata = 32'({nopre, mode_div});
      SEL_CMD:   rdata = 32'(cmd_q);
      SEL_ADDR: begin
        rdata[PHY_AW-1:0]          = phy;
        rdata[REG_LSB +: REG_AW]   = regad;
      end
      SEL_WDATA: rdata = 32'(wr_data);
      SEL_RDATA: rdata = 32'(rd_data);
      SEL_STAT:  rdata = 32'(status);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [2:0]        cmd_wval,
  input  logic              scan_keep,
  input  logic              nopre,
  input  logic [PHY_AW-1:0] phy,
  input  logic [REG_AW-1:0] regad,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              link_fail,
  output logic              scan_invalid,
  output logic              accept_evt,
  output logic              done_evt,
  output logic              is_rd,
  output logic [POS_W-1:0]  pos
);
  localparam logic [POS_W-1:0] DATA_TOP = POS_W'(DATA_W);
  localparam logic [POS_W-1:0] TA_TOP   = POS_W'(DATA_W + 1);

  logic [FRAME_W-1:0] frame_q;
  logic [DATA_W-1:0]  rx_sh;
  logic               scan_mode;
  mdio_op_e           new_op;
  logic               reload;

  assign new_op     = pick_op(cmd_wval);
  assign accept_evt = cmd_wr && !busy && (new_op != OP_NONE);
  assign done_evt   = busy && fall_evt && (pos == '0);
  assign reload     = done_evt && scan_mode && scan_keep;

  assign mdio_o  = busy ? frame_q[pos] : 1'b1;
  assign mdio_oe = busy && !(is_rd && (pos <= TA_TOP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      frame_q      <= '0;
      pos          <= '0;
      is_rd        <= 1'b0;
      scan_mode    <= 1'b0;
      rx_sh        <= '0;
      rd_data      <= '0;
      link_fail    <= 1'b0;
      scan_invalid <= 1'b0;
    end else if (accept_evt) begin
      busy      <= 1'b1;
      frame_q   <= build_frame(new_op, phy, regad, wr_data);
      pos       <= first_pos(nopre);
      is_rd     <= (new_op == OP_RD);
      scan_mode <= (cmd_wval == 3'b001);
      if (cmd_wval == 3'b001) scan_invalid <= 1'b1;
    end else if (busy) begin
      if (rise_evt && is_rd && (pos < DATA_TOP))
        rx_sh <= {rx_sh[DATA_W-2:0], mdio_i};
      if (done_evt) begin
        if (is_rd) rd_data <= rx_sh;
        if (scan_mode) begin
          link_fail    <= rx_sh[LINK_BIT];
          scan_invalid <= 1'b0;
        end
        if (reload) begin
          frame_q <= build_frame(OP_RD, phy, regad, wr_data);
          pos     <= first_pos(nopre);
        end else begin
          busy      <= 1'b0;
          scan_mode <= 1'b0;
        end
      end else if (fall_evt) begin
        pos <= pos - 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter logic [DIV_W-1:0] DIV_RESET = 8'd100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  host_sel,
  input  logic        host_we,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [DIV_W-1:0]  mode_div;
  logic              nopre;
  logic [2:0]        cmd_q;
  logic              cmd_wr;
  logic [2:0]        cmd_wval;
  logic [PHY_AW-1:0] phy;
  logic [REG_AW-1:0] regad;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  logic              busy;
  logic              link_fail;
  logic              scan_invalid;
  logic              accept_evt;
  logic              done_evt;
  logic              rise_evt;
  logic              fall_evt;
  logic              is_rd;
  logic [POS_W-1:0]  pos;
  logic [2:0]        status;

  assign status = {scan_invalid, busy, link_fail};

  mdio_host_regs #(.DIV_RESET(DIV_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(host_sel), .we(host_we), .wdata(host_wdata),
    .rd_data(rd_data), .status(status), .mode_div(mode_div), .nopre(nopre),
    .cmd_q(cmd_q), .cmd_wr(cmd_wr), .cmd_wval(cmd_wval), .phy(phy), .regad(regad),
    .wr_data(wr_data), .rdata(host_rdata)
  );

  mdio_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .half(half_period(mode_div)),
    .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wval(cmd_wval),
    .scan_keep(cmd_q[0]), .nopre(nopre), .phy(phy), .regad(regad),
    .wr_data(wr_data), .rise_evt(rise_evt), .fall_evt(fall_evt), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_data(rd_data),
    .link_fail(link_fail), .scan_invalid(scan_invalid), .accept_evt(accept_evt),
    .done_evt(done_evt), .is_rd(is_rd), .pos(pos)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              busy,
  input logic              accept_evt,
  input logic              done_evt,
  input logic              scan_invalid,
  input logic [DATA_W-1:0] rd_data
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  a_r1_clock_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> busy);

  a_r2_data_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $stable(mdio_o));

  a_r5_rdata_at_end_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(done_evt) |-> $stable(rd_data));

  a_r6_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> busy);

  a_r6_busy_drop_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done_evt));

  a_r9_invalid_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_invalid) |-> $past(done_evt));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy), .accept_evt(accept_evt), .done_evt(done_evt),
  .scan_invalid(scan_invalid), .rd_data(rd_data)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  import mdio_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  host_sel = '0;
  logic        host_we = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #5 clk = ~clk;

  mdio_master dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  typedef struct {
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  ra;
    logic [15:0] data;
    int          pre;
    int          period;
  } exp_t;

  exp_t   expq[$];
  int     checks = 0;
  int     fails = 0;
  int     frames_seen = 0;
  bit     finished = 0;
  logic [7:0] cur_div = 8'd100;
  bit     cur_nopre = 0;
  longint m_tp;
  int     m_pmin, m_pmax;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] resp(input logic [4:0] p, input logic [4:0] r);
    return {p, r, ~p, r[0]};
  endfunction

  function automatic int exp_period(input logic [7:0] d);
    int h;
    h = int'(d) / 2;
    if (h < 1) h = 1;
    return 2 * h;
  endfunction

  task automatic hw(input logic [2:0] s, input logic [31:0] v);
    @(negedge clk);
    host_sel = s; host_wdata = v; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hr(input logic [2:0] s, output logic [31:0] v);
    @(negedge clk);
    host_sel = s;
    #1 v = host_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    do hr(SEL_STAT, st); while (st[1]);
  endtask

  task automatic set_mode(input logic [7:0] d, input bit np);
    cur_div = d; cur_nopre = np;
    hw(SEL_MODE, {23'd0, np, d});
  endtask

  task automatic push(input logic [1:0] op, input logic [4:0] p, input logic [4:0] r,
                      input logic [15:0] d);
    exp_t e;
    e.op = op; e.phy = p; e.ra = r; e.data = d;
    e.pre = cur_nopre ? 0 : 32;
    e.period = exp_period(cur_div);
    expq.push_back(e);
  endtask

  // scoreboard driver: one single command, expected frame pushed first
  task automatic run_cmd(input logic [2:0] cmd, input logic [1:0] op, input logic [4:0] p,
                         input logic [4:0] r, input logic [15:0] d, input string req);
    logic [31:0] v;
    int base;
    base = frames_seen;
    push(op, p, r, (op == 2'b10) ? resp(p, r) : d);
    hw(SEL_ADDR, {19'd0, r, 3'd0, p});
    hw(SEL_WDATA, {16'd0, d});
    hw(SEL_CMD, {29'd0, cmd});
    hr(SEL_STAT, v);
    chk("R6", "busy after accept", {31'd0, v[1]}, 32'd1);
    wait_idle();
    hw(SEL_CMD, 32'd0);
    chk("R1", "idle mdc/oe", {30'd0, mdc, mdio_oe}, 32'd0);
    chk(req, "one frame per command", frames_seen - base, 32'd1);
    if (op == 2'b10) begin
      hr(SEL_RDATA, v);
      chk("R5", "read data register", v, {16'd0, resp(p, r)});
    end
  endtask

  task automatic mon_rise(output bit b);
    longint t;
    int p;
    @(posedge mdc);
    b = mdio_o;
    t = $time;
    if (m_tp >= 0) begin
      p = int'((t - m_tp) / 10);
      if (p < m_pmin) m_pmin = p;
      if (p > m_pmax) m_pmax = p;
    end
    m_tp = t;
  endtask

  // monitor / PHY responder
  initial begin
    forever begin
      bit b;
      int ones;
      logic [1:0] op, ta;
      logic [4:0] ph, ra;
      logic [15:0] dat, rv;
      bit oe_bad, st_bad;
      exp_t e;
      @(posedge mdio_oe);
      m_tp = -1; m_pmin = 1000000; m_pmax = 0;
      ones = 0; oe_bad = 0; st_bad = 0; ta = '0; dat = '0;
      do begin
        mon_rise(b);
        if (b) ones++;
      end while (b && ones < 40);
      mon_rise(b);
      if (!b) st_bad = 1;
      for (int k = 0; k < 2; k++) begin mon_rise(b); op = {op[0], b}; end
      for (int k = 0; k < 5; k++) begin mon_rise(b); ph = {ph[3:0], b}; end
      for (int k = 0; k < 5; k++) begin mon_rise(b); ra = {ra[3:0], b}; end
      if (op == 2'b10) begin
        rv = resp(ph, ra);
        for (int k = 0; k < 18; k++) begin
          @(negedge mdc);
          mdio_i = (k == 0) ? 1'b1 : (k == 1) ? 1'b0 : rv[17-k];
          mon_rise(b);
          if (mdio_oe) oe_bad = 1;
        end
        @(negedge mdc);
        mdio_i = 1'b1;
        dat = rv;
      end else begin
        for (int k = 0; k < 18; k++) begin
          mon_rise(b);
          if (!mdio_oe) oe_bad = 1;
          if (k < 2) ta = {ta[0], b};
          else dat = {dat[14:0], b};
        end
      end
      if (expq.size() == 0) begin
        checks++; fails++;
        $display("FAIL R7 unexpected frame: actual op %b expected none", op);
      end else begin
        e = expq.pop_front();
        chk("R2", "start bits", {31'd0, st_bad}, 32'd0);
        chk("R2", "opcode", {30'd0, op}, {30'd0, e.op});
        chk("R2", "phy address", {27'd0, ph}, {27'd0, e.phy});
        chk("R2", "register address", {27'd0, ra}, {27'd0, e.ra});
        chk("R3", "preamble length", ones, e.pre);
        chk("R1", "mdc period min", m_pmin, e.period);
        chk("R1", "mdc period max", m_pmax, e.period);
        if (op == 2'b01) begin
          chk("R4", "turnaround", {30'd0, ta}, 32'd2);
          chk("R4", "write data", {16'd0, dat}, {16'd0, e.data});
          chk("R4", "oe held", {31'd0, oe_bad}, 32'd0);
        end else begin
          chk("R5", "oe released", {31'd0, oe_bad}, 32'd0);
        end
      end
      frames_seen++;
    end
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, rd0;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    hr(SEL_STAT, v);  chk("R10", "status reset", v, 32'd0);
    hr(SEL_RDATA, v); chk("R10", "rdata reset", v, 32'd0);
    hr(SEL_MODE, v);  chk("R10", "mode reset", v, 32'd100);
    chk("R1", "reset pins", {29'd0, mdc, mdio_oe, mdio_o}, 32'd1);

    set_mode(8'd4, 0);
    run_cmd(3'b100, 2'b01, 5'h11, 5'h03, 16'hA5C3, "R4");
    run_cmd(3'b010, 2'b10, 5'h05, 5'h1A, 16'h0, "R5");
    set_mode(8'd7, 1);
    run_cmd(3'b100, 2'b01, 5'h1F, 5'h00, 16'h8001, "R3");
    run_cmd(3'b010, 2'b10, 5'h0A, 5'h15, 16'h0, "R3");
    set_mode(8'd0, 0);
    run_cmd(3'b110, 2'b01, 5'h02, 5'h09, 16'h3C3C, "R7");
    set_mode(8'd9, 0);
    run_cmd(3'b011, 2'b10, 5'h13, 5'h07, 16'h0, "R7");
    set_mode(8'd4, 0);

    // R7 command write while busy is ignored
    hr(SEL_RDATA, rd0);
    base = frames_seen;
    push(2'b01, 5'h06, 5'h02, 16'h1234);
    hw(SEL_ADDR, {19'd0, 5'h02, 3'd0, 5'h06});
    hw(SEL_WDATA, 32'h1234);
    hw(SEL_CMD, 32'd4);
    repeat (20) @(negedge clk);
    hw(SEL_CMD, 32'd2);
    wait_idle();
    hw(SEL_CMD, 32'd0);
    repeat (200) @(negedge clk);
    chk("R7", "frames after busy write", frames_seen - base, 32'd1);
    hr(SEL_RDATA, v);
    chk("R7", "rdata untouched", v, rd0);

    // R8/R9 scan, link bit from ~phy[1] = 1
    base = frames_seen;
    for (int i = 0; i < 6; i++) push(2'b10, 5'h05, 5'h01, resp(5'h05, 5'h01));
    hw(SEL_ADDR, {19'd0, 5'h01, 3'd0, 5'h05});
    hw(SEL_CMD, 32'd1);
    hr(SEL_STAT, v);
    chk("R9", "invalid and busy at scan start", v, 32'd6);
    wait (frames_seen >= base + 1);
    repeat (12) @(negedge clk);
    hr(SEL_STAT, v);
    chk("R9", "status after first scan read", v, {29'd0, 1'b0, 1'b1, resp(5'h05, 5'h01)[2]});
    hr(SEL_RDATA, v);
    chk("R8", "scan read data", v, {16'd0, resp(5'h05, 5'h01)});
    wait (frames_seen >= base + 2);
    hw(SEL_CMD, 32'd0);
    wait_idle();
    base = frames_seen;
    expq.delete();
    repeat (300) @(negedge clk);
    chk("R8", "no frame after scan stop", frames_seen - base, 32'd0);

    // second scan, link bit 0
    base = frames_seen;
    for (int i = 0; i < 6; i++) push(2'b10, 5'h02, 5'h1C, resp(5'h02, 5'h1C));
    hw(SEL_ADDR, {19'd0, 5'h1C, 3'd0, 5'h02});
    hw(SEL_CMD, 32'd1);
    wait (frames_seen >= base + 2);
    repeat (12) @(negedge clk);
    hr(SEL_STAT, v);
    chk("R9", "link bit cleared", {31'd0, v[0]}, {31'd0, resp(5'h02, 5'h1C)[2]});
    hw(SEL_CMD, 32'd0);
    wait_idle();
    expq.delete();
    chk("R1", "idle after scan", {30'd0, mdc, mdio_oe}, 32'd0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule